// File: doc/BRIEF.md
# Wake Request Output Shaper

This block turns a latched power-management event into two board-level signals. One is a pull-enable for an active-low, open-drain PME# line. The other is a wake line whose shape software selects. The wake line can be a steady level, either active high or active low. It can also be a single timed pulse, either positive or negative. An optional gate holds the wake line back until PME# is being pulled and the isolate input is low, which means main power is gone.

When the card-bus enable is set, the same wake pin becomes a plain active-high status-change level that follows the pending event. The style and gating selects have no effect in that mode. A pending event stays pending until software writes the clear bit through a small write port. Event detection is done upstream, and the block sees only a one-cycle strobe.

The block is a four-state machine:

- **IDLE**: nothing is pending.
- **WAIT**: an event is pending, but the gate is closed.
- **ACTIVE**: the wake line is at its asserted level.
- **SPENT**: a pulse has finished, and the event is still pending.

The transitions are:

- **arm**: IDLE to ACTIVE when the gate is open, or IDLE to WAIT when it is closed, on an event strobe.
- **open**: WAIT to ACTIVE when the gate opens.
- **close**: ACTIVE to WAIT in a level style when the gate closes.
- **expire**: ACTIVE to SPENT when the pulse timer ends.
- **restyle**: SPENT back to ACTIVE or WAIT if the style changes to a level.
- **clear**: any state to IDLE on a clear write. If an event arrives in the same cycle, the clear is followed at once by arm.

Top module: `wake_shaper`

## Requirements
- R1: During and right after reset, with all selects at 0, `pme_pull_o` is 0 and `wake_o` is 0 (active-high level style is the default).
- R2: The style is set by `pulse_sel_i` and `neg_sel_i`. Pulse 0 / neg 0 is a high level, 0/1 a low level, 1/0 a positive pulse and 1/1 a negative pulse. With nothing pending, `wake_o` equals `neg_sel_i`.
- R3: With gating off, an event strobe sampled on one edge makes `pme_pull_o` go to 1 and `wake_o` go to its asserted level in the same following cycle.
- R4: With gating on (`gate_sel_i`=1, card-bus off), `wake_o` stays inactive while `iso_n_i` is 1. It asserts in the cycle after `iso_n_i` is sampled 0 while the event is pending.
- R5: With `cardbus_en_i`=1, `wake_o` is high exactly while an event is pending, ungated, whatever the style and gating selects say.
- R6: `pme_pull_o` (1 = pull PME# low) rises on the cycle after an event strobe and stays 1 until a clear write.
- R7: In a pulse style each event gives exactly PULSE_W asserted cycles (default 16). A further strobe during the pulse or after it, before a clear, produces no extra asserted cycles.
- R8: In a level style the asserted level holds for as long as the event is pending and the gate is open.
- R9: A write with `wr_en_i`=1 and bit CLR_BIT (bit 0) of `wr_data_i` set returns both outputs to idle on the next cycle. A write with that bit at 0 has no effect. A clear together with a strobe leaves the event pending.
- R10: Holding `iso_n_i` low never stops either output from asserting.
- R11: In a gated level style, `iso_n_i` returning to 1 drops `wake_o` to inactive on the next cycle, while `pme_pull_o` stays 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| evt_i | input | 1 | One-cycle power-management event strobe |
| iso_n_i | input | 1 | Isolate input, low while main power is absent |
| cardbus_en_i | input | 1 | Selects fixed active-high status-change output |
| pulse_sel_i | input | 1 | 0 = level style, 1 = pulse style |
| neg_sel_i | input | 1 | 0 = high-going, 1 = low-going |
| gate_sel_i | input | 1 | 1 = assert wake only while PME# pulled and isolate low |
| wr_en_i | input | 1 | Write strobe for the clear register |
| wr_data_i | input | DATA_W | Write data; bit CLR_BIT clears the pending event |
| wake_o | output | 1 | Shaped wake output |
| pme_pull_o | output | 1 | 1 = pull PME# low; the line is never driven high |

## Verification
Several properties are checked on every cycle:

- PME# and wake assert together when gating is off.
- The gate holds wake inactive while isolate is high in a level style.
- In card-bus mode, wake mirrors the PME pull.
- The pending state persists until a clear and ends on a clear.
- An asserted pulse never exceeds PULSE_W cycles.

Some behaviour only the bench scenarios can show. These are the exact pulse length under a repeated strobe, the idle level of each of the four styles, and the release of a gated output when isolate falls and rises again. The bench shows them by sweeping every combination of card-bus, style, polarity, gating and isolate.

// File: rtl/wake_shaper_pkg.sv
package wake_shaper_pkg;
    typedef enum logic [1:0] {
        ST_IDLE,
        ST_WAIT,
        ST_ACTIVE,
        ST_SPENT
    } wake_state_e;

    typedef struct packed {
        logic pulse;
        logic invert;
        logic gated;
    } wake_mode_t;
endpackage

// File: rtl/wake_mode_decode.sv
module wake_mode_decode
    import wake_shaper_pkg::*;
(
    input  logic       cardbus_en,
    input  logic       pulse_sel,
    input  logic       neg_sel,
    input  logic       gate_sel,
    input  logic       iso_n,
    output wake_mode_t mode,
    output logic       gate_open
);
    always_comb begin
        if (cardbus_en) begin
            mode = '{pulse: 1'b0, invert: 1'b0, gated: 1'b0};
        end else begin
            mode = '{pulse: pulse_sel, invert: neg_sel, gated: gate_sel};
        end
        gate_open = !mode.gated || !iso_n;
    end
endmodule

// File: rtl/wake_pulse_timer.sv
module wake_pulse_timer #(
    parameter int PULSE_W = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    output logic done
);
    localparam int CNT_W = (PULSE_W < 2) ? 1 : $clog2(PULSE_W);
    localparam logic [CNT_W-1:0] LAST = CNT_W'(PULSE_W - 1);

    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (!rst_n || !run) begin
            cnt_q <= '0;
        end else if (cnt_q != LAST) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    assign done = run && (cnt_q == LAST);
endmodule

// File: rtl/wake_fsm.sv
module wake_fsm
    import wake_shaper_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        evt,
    input  logic        clr,
    input  logic        gate_open,
    input  wake_mode_t  mode,
    input  logic        pulse_done,
    output wake_state_e state,
    output logic        asserted,
    output logic        pending
);
    wake_state_e state_q, state_d, arm_to;

    always_comb begin
        arm_to  = gate_open ? ST_ACTIVE : ST_WAIT;
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (evt) state_d = arm_to;
            end
            ST_WAIT: begin
                if (clr)            state_d = evt ? arm_to : ST_IDLE;
                else if (gate_open) state_d = ST_ACTIVE;
            end
            ST_ACTIVE: begin
                if (clr)                          state_d = evt ? arm_to : ST_IDLE;
                else if (mode.pulse && pulse_done) state_d = ST_SPENT;
                else if (!mode.pulse && !gate_open) state_d = ST_WAIT;
            end
            ST_SPENT: begin
                if (clr)              state_d = evt ? arm_to : ST_IDLE;
                else if (!mode.pulse) state_d = arm_to;
            end
            default: state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state    = state_q;
        asserted = (state_q == ST_ACTIVE);
        pending  = (state_q != ST_IDLE);
    end
endmodule

// File: rtl/wake_shaper.sv
module wake_shaper
    import wake_shaper_pkg::*;
#(
    parameter int PULSE_W = 16,
    parameter int DATA_W  = 8,
    parameter int CLR_BIT = 0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              evt_i,
    input  logic              iso_n_i,
    input  logic              cardbus_en_i,
    input  logic              pulse_sel_i,
    input  logic              neg_sel_i,
    input  logic              gate_sel_i,
    input  logic              wr_en_i,
    input  logic [DATA_W-1:0] wr_data_i,
    output logic              wake_o,
    output logic              pme_pull_o
);
    wake_mode_t  mode;
    wake_state_e state;
    logic        gate_open, clr, pulse_done, asserted, pending;

    assign clr = wr_en_i && wr_data_i[CLR_BIT];

    wake_mode_decode u_dec (
        .cardbus_en (cardbus_en_i),
        .pulse_sel  (pulse_sel_i),
        .neg_sel    (neg_sel_i),
        .gate_sel   (gate_sel_i),
        .iso_n      (iso_n_i),
        .mode       (mode),
        .gate_open  (gate_open)
    );

    wake_pulse_timer #(.PULSE_W(PULSE_W)) u_tmr (
        .clk   (clk),
        .rst_n (rst_n),
        .run   (state == ST_ACTIVE),
        .done  (pulse_done)
    );

    wake_fsm u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .evt        (evt_i),
        .clr        (clr),
        .gate_open  (gate_open),
        .mode       (mode),
        .pulse_done (pulse_done),
        .state      (state),
        .asserted   (asserted),
        .pending    (pending)
    );

    always_comb begin
        wake_o     = asserted ^ mode.invert;
        pme_pull_o = pending;
    end
endmodule

// File: rtl/wake_shaper_chk.sv
module wake_shaper_chk #(
    parameter int PULSE_W = 16,
    parameter int DATA_W  = 8,
    parameter int CLR_BIT = 0
) (
    input logic              clk,
    input logic              rst_n,
    input logic              evt_i,
    input logic              iso_n_i,
    input logic              cardbus_en_i,
    input logic              pulse_sel_i,
    input logic              neg_sel_i,
    input logic              gate_sel_i,
    input logic              wr_en_i,
    input logic [DATA_W-1:0] wr_data_i,
    input logic              wake_o,
    input logic              pme_pull_o
);
    localparam int CW = $clog2(PULSE_W + 2);

    logic          clr_w, pulse_mode, inv_lvl;
    logic [CW-1:0] run_len;

    assign clr_w      = wr_en_i && wr_data_i[CLR_BIT];
    assign pulse_mode = pulse_sel_i && !cardbus_en_i;
    assign inv_lvl    = neg_sel_i && !cardbus_en_i;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            run_len <= '0;
        end else if (pulse_mode && (wake_o != inv_lvl)) begin
            if (run_len != CW'(PULSE_W + 1)) run_len <= run_len + 1'b1;
        end else begin
            run_len <= '0;
        end
    end

    // R3: ungated event asserts wake and PME together
    a_r3_same_cycle: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(evt_i) && !$past(pme_pull_o) && ($past(cardbus_en_i) || !$past(gate_sel_i))
         && $stable(cardbus_en_i) && $stable(neg_sel_i))
        |-> (pme_pull_o && (wake_o != inv_lvl)));

    // R4: closed gate keeps a level-style wake inactive
    a_r4_gate_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (!cardbus_en_i && gate_sel_i && iso_n_i && !pulse_sel_i
         && $past(!cardbus_en_i && gate_sel_i && iso_n_i && !pulse_sel_i))
        |-> (wake_o == neg_sel_i));

    // R5: card-bus mode mirrors the pending state, active high
    a_r5_cardbus_mirror: assert property (@(posedge clk) disable iff (!rst_n)
        (cardbus_en_i && $past(cardbus_en_i)) |-> (wake_o == pme_pull_o));

    // R6: PME pull persists until a clear write
    a_r6_pme_holds: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(pme_pull_o) && !$past(clr_w)) |-> pme_pull_o);

    // R9: clear without a simultaneous event releases PME
    a_r9_clear: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(clr_w) && !$past(evt_i)) |-> !pme_pull_o);

    // R7: an asserted pulse never outlasts its width
    a_r7_pulse_bounded: assert property (@(posedge clk) disable iff (!rst_n)
        run_len <= CW'(PULSE_W));
endmodule

bind wake_shaper wake_shaper_chk #(
    .PULSE_W (PULSE_W),
    .DATA_W  (DATA_W),
    .CLR_BIT (CLR_BIT)
) u_chk (.*);

// File: tb/tb_wake_shaper.sv
module tb_wake_shaper;
    localparam int CLK_PERIOD = 10;
    localparam int W  = 16;
    localparam int DW = 8;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          evt = 1'b0, iso_n = 1'b1, cb = 1'b0, psel = 1'b0, nsel = 1'b0, gsel = 1'b0;
    logic          wr_en = 1'b0;
    logic [DW-1:0] wr_data = '0;
    logic          wake, pme;

    int n_chk = 0;
    int n_bad = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    wake_shaper #(.PULSE_W(W), .DATA_W(DW), .CLR_BIT(0)) dut (
        .clk (clk), .rst_n (rst_n), .evt_i (evt), .iso_n_i (iso_n),
        .cardbus_en_i (cb), .pulse_sel_i (psel), .neg_sel_i (nsel), .gate_sel_i (gsel),
        .wr_en_i (wr_en), .wr_data_i (wr_data), .wake_o (wake), .pme_pull_o (pme)
    );

    task automatic check(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d (cb=%0d p=%0d n=%0d g=%0d iso_n=%0d)",
                     req, act, exp, cb, psel, nsel, gsel, iso_n);
        end
    endtask

    task automatic step();
        @(negedge clk);
    endtask

    task automatic do_reset();
        rst_n = 1'b0; evt = 1'b0; wr_en = 1'b0; wr_data = '0;
        step(); step();
        rst_n = 1'b1;
        step();
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        n_chk++; n_bad++;
        $display("FAIL watchdog: actual running expected finished");
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

    initial begin
        step();
        check("R1 wake in reset", int'(wake), 0);
        check("R1 pme in reset", int'(pme), 0);
        do_reset();
        check("R1 wake after reset", int'(wake), 0);
        check("R1 pme after reset", int'(pme), 0);

        for (int c = 0; c < 32; c++) begin
            logic neg_e, pul_e, gat_e, qual;
            int   act_lvl, idle_lvl, n;
            string tag;
            cb    = c[4]; psel = c[3]; nsel = c[2]; gsel = c[1]; iso_n = c[0];
            neg_e = nsel && !cb;
            pul_e = psel && !cb;
            gat_e = gsel && !cb;
            qual  = !gat_e || !iso_n;
            idle_lvl = int'(neg_e);
            act_lvl  = int'(!neg_e);
            tag = cb ? "R5" : "R2";
            do_reset();
            check({tag, " idle level"}, int'(wake), idle_lvl);
            check("R6 pme idle", int'(pme), 0);

            evt = 1'b1; step(); evt = 1'b0;
            check("R6 pme after event", int'(pme), 1);
            if (qual) begin
                check(cb ? "R5 asserted" : (!iso_n ? "R10 asserted while isolated" : "R3 same cycle"),
                      int'(wake), act_lvl);
                if (pul_e) begin
                    n = 0;
                    for (int i = 0; i < 2*W + 4; i++) begin
                        if (int'(wake) == act_lvl) n++;
                        evt = (i == 4 || i == W + 3);
                        step();
                    end
                    evt = 1'b0;
                    check("R7 pulse width with retrigger", n, W);
                    check("R7 idle after pulse", int'(wake), idle_lvl);
                    check("R6 pme after pulse", int'(pme), 1);
                end else begin
                    for (int i = 0; i < 20; i++) step();
                    check(cb ? "R5 level held" : "R8 level held", int'(wake), act_lvl);
                end
            end else begin
                step(); step();
                check("R4 gate holds off", int'(wake), idle_lvl);
                iso_n = 1'b0; step();
                check("R4 asserts after isolate low", int'(wake), act_lvl);
                check("R10 pme while isolated", int'(pme), 1);
                if (!pul_e) begin
                    iso_n = 1'b1; step();
                    check("R11 drop on isolate high", int'(wake), idle_lvl);
                    check("R11 pme kept", int'(pme), 1);
                end else begin
                    for (int i = 0; i < W + 2; i++) step();
                    check("R7 gated pulse ends", int'(wake), idle_lvl);
                end
            end

            wr_en = 1'b1; wr_data = 8'hFE; step();
            wr_en = 1'b0; wr_data = '0;
            check("R9 write without clear bit", int'(pme), 1);
            wr_en = 1'b1; wr_data = 8'h01; step();
            wr_en = 1'b0; wr_data = '0;
            check("R9 pme cleared", int'(pme), 0);
            check("R9 wake idle after clear", int'(wake), idle_lvl);
        end

        cb = 0; psel = 0; nsel = 0; gsel = 0; iso_n = 1;
        do_reset();
        evt = 1'b1; step(); evt = 1'b0;
        wr_en = 1'b1; wr_data = 8'h01; evt = 1'b1; step();
        wr_en = 1'b0; wr_data = '0; evt = 1'b0;
        check("R9 clear with event keeps pending", int'(pme), 1);
        check("R9 clear with event keeps wake", int'(wake), 1);

        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end
endmodule